// File: doc/BRIEF.md
# Address-Gated Input Hold Gate

This block sits between a shared external data bus and the internal logic of a device. While the device is selected, bus data passes straight through to the internal side. While it is not selected, the chosen input bits are frozen at their last passed value. External toggling on those bits then cannot reach internal logic, which saves the switching power that activity would cost.

The open/closed decision comes from one of two sources, chosen by a parameter. In one mode an active-low select input decides it. In the other mode the block compares an incoming address bus against its own address. A run-time mask picks which data bits are subject to freezing; unmasked bits always pass through. The select and address inputs never pass through the mask and are never frozen themselves.

A saturating activity meter counts every bit transition seen on the internal side. It lets a power estimate compare the suppressed activity against the activity the bus would otherwise cause.

Top module: `bus_hold_gate`

## Requirements
- R1: With GATE_SRC=1 (address mode), gateOpen is 1 exactly when addr equals DEV_ADDR, and selN has no effect on it.
- R2: With GATE_SRC=0 (select mode), gateOpen is 1 exactly when selN is 0, and addr has no effect on it.
- R3: While gateOpen is 1, every bit of dataOut equals the same bit of busIn in the same cycle, with no clock delay.
- R4: While gateOpen is 0, each dataOut bit whose gateMask bit is 1 shows the busIn value captured at the last rising clock edge where gateOpen was 1, or 0 if there was none since reset.
- R5: Each dataOut bit whose gateMask bit is 0 equals the same busIn bit at all times, whatever the gate state.
- R6: At each rising clock edge out of reset, toggleCount grows by the number of dataOut bits that differ from their value at the previous rising edge. The reference value before the first edge after reset is all zeros.
- R7: toggleCount saturates at 2^CNT_W-1 and stays there.
- R8: Reset (rstN low) clears toggleCount and the held bus value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selN | input | 1 | Active-low external select (used when GATE_SRC=0) |
| addr | input | ADDR_W | Address bus compared with DEV_ADDR (used when GATE_SRC=1) |
| busIn | input | DATA_W | External shared data bus |
| gateMask | input | DATA_W | 1 = bit is frozen while closed, 0 = bit always passes |
| dataOut | output | DATA_W | Internal-side data |
| gateOpen | output | 1 | Current gate state, 1 = open |
| toggleCount | output | CNT_W | Saturating count of internal-side bit transitions |

## Verification
The bench builds two copies with DATA_W=4, ADDR_W=3, DEV_ADDR=5 and CNT_W=8. One copy uses the address source and the other the select source, and both are driven by the same stimulus. With these small widths the bench can sweep every mask value against every address and select state. This covers every frozen/passing bit split under both gate sources. The 8-bit meter is small enough to reach its saturation point within the sweep.

// File: rtl/bus_hold_gate_pkg.sv
package bus_hold_gate_pkg;
  typedef struct packed {
    logic gateOpen;
    logic capture;
  } gate_strobe_t;
endpackage

// File: rtl/gate_ctrl.sv
module gate_ctrl
  import bus_hold_gate_pkg::*;
#(
  parameter int unsigned GATE_SRC = 1,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned DEV_ADDR = 5
) (
  input  logic              selN,
  input  logic [ADDR_W-1:0] addr,
  output gate_strobe_t      strobe
);
  localparam logic [ADDR_W-1:0] OwnAddr = ADDR_W'(DEV_ADDR);
  localparam logic UseAddr = (GATE_SRC != 0);

  logic addrHit;
  logic selHit;

  always_comb begin
    addrHit = (addr == OwnAddr);
    selHit  = ~selN;
    strobe.gateOpen = UseAddr ? addrHit : selHit;
    strobe.capture  = strobe.gateOpen;
  end
endmodule

// File: rtl/hold_path.sv
module hold_path
  import bus_hold_gate_pkg::*;
#(
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  gate_strobe_t      strobe,
  input  logic [DATA_W-1:0] busIn,
  input  logic [DATA_W-1:0] gateMask,
  output logic [DATA_W-1:0] dataOut
);
  logic [DATA_W-1:0] holdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdReg <= '0;
    else if (strobe.capture) holdReg <= busIn;
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign dataOut[b] = (gateMask[b] && !strobe.gateOpen) ? holdReg[b] : busIn[b];
  end
endmodule

// File: rtl/toggle_meter.sv
module toggle_meter #(
  parameter int unsigned DATA_W = 4,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataOut,
  output logic [CNT_W-1:0]  toggleCount
);
  localparam int unsigned IncW = $clog2(DATA_W + 1);
  localparam logic [CNT_W:0] CntMax = {1'b0, {CNT_W{1'b1}}};

  logic [DATA_W-1:0] prevOut;
  logic [IncW-1:0]   flips;
  logic [CNT_W:0]    sum;

  always_comb begin
    flips = '0;
    for (int i = 0; i < DATA_W; i++) begin
      flips = flips + IncW'(dataOut[i] ^ prevOut[i]);
    end
    sum = {1'b0, toggleCount} + (CNT_W + 1)'(flips);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevOut     <= '0;
      toggleCount <= '0;
    end else begin
      prevOut     <= dataOut;
      toggleCount <= (sum > CntMax) ? CntMax[CNT_W-1:0] : sum[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/bus_hold_gate.sv
module bus_hold_gate
  import bus_hold_gate_pkg::*;
#(
  parameter int unsigned GATE_SRC = 1,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned DEV_ADDR = 5,
  parameter int unsigned DATA_W   = 4,
  parameter int unsigned CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] busIn,
  input  logic [DATA_W-1:0] gateMask,
  output logic [DATA_W-1:0] dataOut,
  output logic              gateOpen,
  output logic [CNT_W-1:0]  toggleCount
);
  gate_strobe_t strobe;

  gate_ctrl #(.GATE_SRC(GATE_SRC), .ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) ctrl_i (
    .selN(selN), .addr(addr), .strobe(strobe)
  );

  hold_path #(.DATA_W(DATA_W)) path_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .busIn(busIn), .gateMask(gateMask), .dataOut(dataOut)
  );

  toggle_meter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) meter_i (
    .clk(clk), .rstN(rstN), .dataOut(dataOut), .toggleCount(toggleCount)
  );

  assign gateOpen = strobe.gateOpen;
endmodule

// File: rtl/bus_hold_gate_chk.sv
module bus_hold_gate_chk #(
  parameter int unsigned DATA_W = 4,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] busIn,
  input logic [DATA_W-1:0] gateMask,
  input logic [DATA_W-1:0] dataOut,
  input logic              gateOpen,
  input logic [CNT_W-1:0]  toggleCount
);
  localparam logic [CNT_W-1:0] CntTop = {CNT_W{1'b1}};

  p_open_pass_r3: assert property (@(posedge clk) disable iff (!rstN)
    gateOpen |-> (dataOut == busIn));

  p_closed_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!gateOpen && !$past(gateOpen) && $stable(gateMask))
      |-> (((dataOut ^ $past(dataOut)) & gateMask) == '0));

  p_unmasked_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((~gateMask) & (dataOut ^ busIn)) == '0);

  p_count_rises_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (toggleCount >= $past(toggleCount)));

  p_count_sat_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(toggleCount) == CntTop) |-> (toggleCount == CntTop));
endmodule

bind bus_hold_gate bus_hold_gate_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .busIn(busIn), .gateMask(gateMask),
  .dataOut(dataOut), .gateOpen(gateOpen), .toggleCount(toggleCount)
);

// File: tb/bus_hold_gate_tb_top.sv
module bus_hold_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int DW = 4;
  localparam int CW = 8;
  localparam int OWN = 5;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0;
  logic rstN = 0;
  logic selN = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] busIn = '0;
  logic [DW-1:0] gateMask = '1;
  logic [DW-1:0] outA, outE;
  logic openA, openE;
  logic [CW-1:0] cntA, cntE;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int holdA = 0, holdE = 0, cntExpA = 0, cntExpE = 0, prevA = 0, prevE = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_hold_gate #(.GATE_SRC(1), .ADDR_W(AW), .DEV_ADDR(OWN), .DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .selN(selN), .addr(addr), .busIn(busIn), .gateMask(gateMask),
    .dataOut(outA), .gateOpen(openA), .toggleCount(cntA));

  bus_hold_gate #(.GATE_SRC(0), .ADDR_W(AW), .DEV_ADDR(OWN), .DATA_W(DW), .CNT_W(CW)) dutExt_i (
    .clk(clk), .rstN(rstN), .selN(selN), .addr(addr), .busIn(busIn), .gateMask(gateMask),
    .dataOut(outE), .gateOpen(openE), .toggleCount(cntE));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expOut(input int open, input int hold, input int bus, input int mask);
    if (open != 0) return bus;
    return ((mask & hold) | (~mask & bus)) & ((1 << DW) - 1);
  endfunction

  function automatic int pop(input int v);
    int n = 0;
    for (int i = 0; i < DW; i++) n += (v >> i) & 1;
    return n;
  endfunction

  // Called at a falling edge; drives, checks combinational outputs, then the edge results.
  task automatic step(input int a, input int s, input int b, input int m);
    int oa, oe, ea, ee;
    addr = AW'(a); selN = s[0]; busIn = DW'(b); gateMask = DW'(m);
    #1;
    oa = (a == OWN) ? 1 : 0;
    oe = (s == 0) ? 1 : 0;
    check("R1 address-mode gate", int'(openA), oa);
    check("R2 select-mode gate", int'(openE), oe);
    ea = expOut(oa, holdA, b, m);
    ee = expOut(oe, holdE, b, m);
    check(oa != 0 ? "R3 open pass (addr mode)" : "R4/R5 closed hold (addr mode)", int'(outA), ea);
    check(oe != 0 ? "R3 open pass (select mode)" : "R4/R5 closed hold (select mode)", int'(outE), ee);
    @(posedge clk);
    #1;
    if (oa != 0) holdA = b;
    if (oe != 0) holdE = b;
    cntExpA += pop(ea ^ prevA); if (cntExpA > CMAX) cntExpA = CMAX; prevA = ea;
    cntExpE += pop(ee ^ prevE); if (cntExpE > CMAX) cntExpE = CMAX; prevE = ee;
    check("R6/R7 toggle count (addr mode)", int'(cntA), cntExpA);
    check("R6/R7 toggle count (select mode)", int'(cntE), cntExpE);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    // R8: closed gate, all bits masked, held value is 0 after reset
    check("R8 reset count (addr mode)", int'(cntA), 0);
    check("R8 reset count (select mode)", int'(cntE), 0);
    check("R8 reset hold (addr mode)", int'(outA), 0);
    check("R8 reset hold (select mode)", int'(outE), 0);

    // Directed: open with 4'hA, then close and toggle the bus (R4)
    step(OWN, 0, 'hA, 'hF);
    step(1, 1, 'h5, 'hF);
    step(2, 1, 'h3, 'hF);
    // Partial mask: low two bits frozen, high two pass (R5)
    step(3, 1, 'hC, 'h3);
    step(OWN, 0, 'h6, 'h3);
    step(0, 1, 'h9, 'h3);

    // Sweep every mask against every address and select state
    for (int m = 0; m < 16; m++) begin
      for (int a = 0; a < 8; a++) begin
        for (int k = 0; k < 2; k++) begin
          step(a, (a + k) & 1, (m * 3 + a * 5 + k * 7) & 15, m);
        end
      end
    end

    // R7: counters are saturated by now; more toggling keeps them at the top
    step(OWN, 0, 'h0, 'h0);
    step(OWN, 0, 'hF, 'h0);
    check("R7 saturated (addr mode)", int'(cntA), CMAX);
    check("R7 saturated (select mode)", int'(cntE), CMAX);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule